// File: doc/BRIEF.md
# Montgomery Squared-Radix Factor Calculator

This block produces the constant F = 2^(2k) mod N that a Montgomery multiplier needs to move operands into the Montgomery domain. N is an odd modulus of k bits, where k is a whole number of 32-bit words. The block fetches N from an external word-wide memory and writes F into a second external memory. It needs no wide adder: it keeps a running value, starting at one, and runs 2k passes over it. Each pass doubles the value and subtracts N when the doubled value is not below N.

Each pass walks the words from least to most significant. A carry bit carries the one-bit left shift from word to word, and a borrow bit carries the trial subtraction. The doubled word and the difference word are both kept in internal storage. When the pass ends, the top carry and the final borrow decide which of the two becomes the new running value, so nothing has to be copied. The modulus memory has a registered read port, so the block presents each read address one cycle before it consumes the data. After the last pass the result goes out one word per cycle through a synchronous write port.

A host loads N, sets the length input to the word count minus one and pulses `start` for one cycle. When `ready` rises again, F is complete in the result memory.

Top module: `sqrFactorTop`

## Requirements
- R1: While `rstN` is low and after it is released, `ready` is 1 and `resWr` is 0 until a start is accepted.
- R2: A `start` pulse seen with `ready` high is accepted, and `ready` is 0 in the following cycle.
- R3: With L = `lenM1`+1 words and k = 32·L, the result memory ends up holding the value from the recurrence F0 = 1, F(i+1) = 2F(i) − N if 2F(i) ≥ N, else 2F(i), after 2k steps. That value is 2^(2k) mod N. Word j (bits 32j+31..32j) is at address j. Modulus word j is read from modulus address j, and read data arrives one cycle after its address.
- R4: In one operation exactly L result writes occur, to addresses 0, 1, …, L−1 in that order, on consecutive cycles. No other result address is written.
- R5: `ready` returns to 1 exactly 2k·(L+1) + L clock cycles after the edge that accepted `start`.
- R6: A `start` pulse, or a change of `lenM1`, while `ready` is 0 has no effect on the result, the written addresses or the completion time.
- R7: `resWr` is only asserted while `ready` is 0, and `ready` is 1 in the cycle after the write to address L−1.
- R8: Pulling `rstN` low during an operation aborts it. `ready` is 1 in the next cycle, and no result write follows.
- R9: Corner moduli give the arithmetic values: N = 3 and N = 2^k − 1 both give F = 1. A modulus with its top bit set, where the doubled value overflows k bits, is still reduced correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle start request |
| ready | output | 1 | High when idle; low while computing or writing out |
| lenM1 | input | ADDR_W | Operand length in words, minus one |
| nAddr | output | ADDR_W | Modulus memory read address |
| nData | input | WORD_W | Modulus memory read data, one cycle after `nAddr` |
| resAddr | output | ADDR_W | Result memory write address |
| resData | output | WORD_W | Result memory write data |
| resWr | output | 1 | Result memory write enable |

## Verification
A wrong carry or borrow hand-off between words, or a wrong selection between the doubled and reduced banks, corrupts the running value during its own pass. The error keeps doubling through every later pass, so almost every result word comes out wrong, and it becomes visible only when the words are written out at the end. A one-cycle slip in the modulus read address has the same effect. Faults in the pass or word counters show up as a changed completion time, a wrong number of writes or writes outside 0..L−1. The bench checks these for every run, across lengths of one to four words and at the 384-bit and 512-bit sizes.

// File: rtl/sqrFactorPkg.sv
package sqrFactorPkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PRIME,
    ST_RUN,
    ST_WRITE
  } ctrlState_t;

  // strobes from the sequencer to the word datapath
  typedef struct packed {
    logic loadOne;    // seed the running value with 1
    logic stepWord;   // process the word at wordIdx
    logic closePass;  // last word of the pass: pick the new running value
    logic emitWord;   // result word at wordIdx is being written out
  } pathCmd_t;

endpackage

// File: rtl/sqrFactorCtrl.sv
module sqrFactorCtrl
  import sqrFactorPkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] lenM1,
  output logic              ready,
  output logic [ADDR_W-1:0] nAddr,
  output logic [ADDR_W-1:0] resAddr,
  output logic              resWr,
  output logic [ADDR_W-1:0] wordIdx,
  output pathCmd_t          cmd
);

  // passes = 2 * 32 * words, so shift the word count by log2(WORD_W)+1
  localparam int SHIFT  = $clog2(WORD_W) + 1;
  localparam int ITER_W = ADDR_W + SHIFT + 1;

  ctrlState_t        state;
  logic [ADDR_W-1:0] lenReg;
  logic [ADDR_W-1:0] idxQ;
  logic [ITER_W-1:0] passCnt;
  logic [ITER_W-1:0] lastPass;
  logic              lastWord;

  assign lastPass = (({{(ITER_W-ADDR_W){1'b0}}, lenReg} + ITER_W'(1)) << SHIFT)
                    - ITER_W'(1);
  assign lastWord = (idxQ == lenReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      lenReg  <= '0;
      idxQ    <= '0;
      passCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            lenReg  <= lenM1;
            passCnt <= '0;
            idxQ    <= '0;
            state   <= ST_PRIME;
          end
        end
        ST_PRIME: begin
          idxQ  <= '0;
          state <= ST_RUN;
        end
        ST_RUN: begin
          if (lastWord) begin
            idxQ <= '0;
            if (passCnt == lastPass) begin
              state <= ST_WRITE;
            end else begin
              passCnt <= passCnt + ITER_W'(1);
              state   <= ST_PRIME;
            end
          end else begin
            idxQ <= idxQ + ADDR_W'(1);
          end
        end
        ST_WRITE: begin
          if (lastWord) begin
            idxQ  <= '0;
            state <= ST_IDLE;
          end else begin
            idxQ <= idxQ + ADDR_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd           = '0;
    cmd.loadOne   = (state == ST_IDLE) && start;
    cmd.stepWord  = (state == ST_RUN);
    cmd.closePass = (state == ST_RUN) && lastWord;
    cmd.emitWord  = (state == ST_WRITE);
  end

  // registered-read memory: present the next word's address one cycle early
  assign nAddr   = (state == ST_RUN) ? (idxQ + ADDR_W'(1)) : '0;
  assign resAddr = idxQ;
  assign resWr   = (state == ST_WRITE);
  assign ready   = (state == ST_IDLE);
  assign wordIdx = idxQ;

endmodule

// File: rtl/sqrFactorPath.sv
module sqrFactorPath
  import sqrFactorPkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  pathCmd_t          cmd,
  input  logic [ADDR_W-1:0] wordIdx,
  input  logic [WORD_W-1:0] nData,
  output logic [WORD_W-1:0] resData
);

  localparam int DEPTH = 1 << ADDR_W;

  // two candidate banks: doubled value and doubled value minus N
  logic [WORD_W-1:0] dblBank [DEPTH];
  logic [WORD_W-1:0] difBank [DEPTH];
  logic              selDif;
  logic              carryQ;
  logic              borrowQ;

  logic [WORD_W-1:0] curWord;
  logic [WORD_W-1:0] dblWord;
  logic [WORD_W-1:0] difWord;
  logic              carryOut;
  logic              borrowOut;
  logic [WORD_W:0]   subWide;

  assign curWord  = selDif ? difBank[wordIdx] : dblBank[wordIdx];
  assign dblWord  = {curWord[WORD_W-2:0], carryQ};
  assign carryOut = curWord[WORD_W-1];
  assign subWide  = {1'b0, dblWord} - {1'b0, nData} - {{WORD_W{1'b0}}, borrowQ};
  assign difWord  = subWide[WORD_W-1:0];
  assign borrowOut = subWide[WORD_W];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dblBank[g] <= '0;
        difBank[g] <= '0;
      end else if (cmd.loadOne) begin
        dblBank[g] <= (g == 0) ? WORD_W'(1) : '0;
        difBank[g] <= '0;
      end else if (cmd.stepWord && (wordIdx == ADDR_W'(g))) begin
        dblBank[g] <= dblWord;
        difBank[g] <= difWord;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selDif  <= 1'b0;
      carryQ  <= 1'b0;
      borrowQ <= 1'b0;
    end else if (cmd.loadOne) begin
      selDif  <= 1'b0;
      carryQ  <= 1'b0;
      borrowQ <= 1'b0;
    end else if (cmd.stepWord) begin
      if (cmd.closePass) begin
        // 2F >= N when the shift overflowed or the subtraction did not borrow
        selDif  <= carryOut | ~borrowOut;
        carryQ  <= 1'b0;
        borrowQ <= 1'b0;
      end else begin
        carryQ  <= carryOut;
        borrowQ <= borrowOut;
      end
    end
  end

  assign resData = curWord;

endmodule

// File: rtl/sqrFactorTop.sv
module sqrFactorTop
  import sqrFactorPkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic              ready,
  input  logic [ADDR_W-1:0] lenM1,
  output logic [ADDR_W-1:0] nAddr,
  input  logic [WORD_W-1:0] nData,
  output logic [ADDR_W-1:0] resAddr,
  output logic [WORD_W-1:0] resData,
  output logic              resWr
);

  pathCmd_t          cmd;
  logic [ADDR_W-1:0] wordIdx;

  sqrFactorCtrl #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .lenM1   (lenM1),
    .ready   (ready),
    .nAddr   (nAddr),
    .resAddr (resAddr),
    .resWr   (resWr),
    .wordIdx (wordIdx),
    .cmd     (cmd)
  );

  sqrFactorPath #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) path_i (
    .clk     (clk),
    .rstN    (rstN),
    .cmd     (cmd),
    .wordIdx (wordIdx),
    .nData   (nData),
    .resData (resData)
  );

endmodule

// File: rtl/sqrFactorChecker.sv
module sqrFactorChecker #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              ready,
  input logic [ADDR_W-1:0] lenM1,
  input logic [ADDR_W-1:0] resAddr,
  input logic              resWr
);

  logic [ADDR_W-1:0] lenSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               lenSeen <= '0;
    else if (ready && start) lenSeen <= lenM1;
  end

  // R2: an accepted start drops ready next cycle
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ready && start) |=> !ready);

  // R7: writes only while busy
  p_write_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    resWr |-> !ready);

  // R4: write address inside the length latched at start
  p_wr_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    resWr |-> (resAddr <= lenSeen));

  // R4: writes ascend by one on consecutive cycles
  p_wr_order_r4: assert property (@(posedge clk) disable iff (!rstN)
    (resWr && (resAddr != '0)) |-> ($past(resWr) && (resAddr == $past(resAddr) + ADDR_W'(1))));

  // R7: ready returns right after the last word
  p_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    (resWr && (resAddr == lenSeen)) |=> ready);

endmodule

bind sqrFactorTop sqrFactorChecker #(.ADDR_W(ADDR_W)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .ready   (ready),
  .lenM1   (lenM1),
  .resAddr (resAddr),
  .resWr   (resWr)
);

// File: tb/sqrFactorTop_tb_top.sv
module sqrFactorTop_tb_top;

  localparam int ADDR_W = 4;
  localparam int WORD_W = 32;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam logic [31:0] SENT = 32'hA5A5_5A5A;

  logic              clk = 1'b0;
  logic              rstN;
  logic              start;
  logic              ready;
  logic [ADDR_W-1:0] lenM1;
  logic [ADDR_W-1:0] nAddr;
  logic [WORD_W-1:0] nData;
  logic [ADDR_W-1:0] resAddr;
  logic [WORD_W-1:0] resData;
  logic              resWr;

  always #2 clk = ~clk;

  sqrFactorTop #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .ready(ready), .lenM1(lenM1),
    .nAddr(nAddr), .nData(nData), .resAddr(resAddr), .resData(resData), .resWr(resWr)
  );

  // memory models
  logic [WORD_W-1:0] nMem [DEPTH];
  logic [WORD_W-1:0] rMem [DEPTH];
  logic [DEPTH-1:0]  wrMask;
  int                wrCnt;
  logic              clrLog;

  always @(posedge clk) nData <= nMem[nAddr];

  always @(posedge clk) begin
    if (clrLog) begin
      wrMask <= '0;
      wrCnt  <= 0;
    end else if (resWr) begin
      rMem[resAddr]   <= resData;
      wrMask[resAddr] <= 1'b1;
      wrCnt           <= wrCnt + 1;
    end
  end

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [511:0] refFactor(int words, logic [511:0] n);
    logic [512:0] t;
    logic [511:0] f;
    f = 512'd1;
    for (int i = 0; i < 64 * words; i++) begin
      t = {f, 1'b0};
      if (t >= {1'b0, n}) t = t - {1'b0, n};
      f = t[511:0];
    end
    return f;
  endfunction

  function automatic logic [511:0] mkRand(int words);
    logic [511:0] n = '0;
    for (int w = 0; w < words; w++) n[32*w +: 32] = $urandom;
    n[1:0] = 2'b11;
    return n;
  endfunction

  function automatic logic [511:0] mkTop(int words);
    logic [511:0] n = '0;
    n[32*words-1] = 1'b1;
    n[0] = 1'b1;
    return n;
  endfunction

  function automatic logic [511:0] mkOnes(int words);
    logic [511:0] n = '0;
    for (int b = 0; b < 32 * words; b++) n[b] = 1'b1;
    return n;
  endfunction

  task automatic runCase(input int len, input logic [511:0] n, input bit poke, input string tag);
    logic [511:0] exp;
    int words, cnt, expLat;
    words  = len + 1;
    exp    = refFactor(words, n);
    expLat = 64 * words * (words + 1) + words;
    for (int i = 0; i < DEPTH; i++) begin
      nMem[i] = (i <= len) ? n[32*i +: 32] : $urandom;
      rMem[i] = SENT;
    end
    @(negedge clk);
    lenM1  = ADDR_W'(len);
    start  = 1'b1;
    clrLog = 1'b1;
    @(negedge clk);
    start  = 1'b0;
    clrLog = 1'b0;
    cnt    = 1;
    chk(ready == 1'b0, "R2 ready after start", 32'(ready), 32'd0);
    while (!ready && cnt < 20000) begin
      @(negedge clk);
      cnt++;
      if (poke && cnt == 5) begin
        start = 1'b1;                          // R6: ignored while busy
        lenM1 = ADDR_W'(len ^ 1);
      end else if (poke && cnt == 6) begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    chk(cnt - 1 == expLat, poke ? "R6 latency with busy start" : "R5 latency",
        32'(cnt - 1), 32'(expLat));
    for (int i = 0; i < words; i++)
      chk(rMem[i] === exp[32*i +: 32], tag, rMem[i], exp[32*i +: 32]);
    chk(wrCnt == words, "R4 write count", 32'(wrCnt), 32'(words));
    chk(wrMask == DEPTH'((1 << words) - 1), "R4 written addresses",
        32'(wrMask), 32'((1 << words) - 1));
    chk(resWr == 1'b0, "R7 no write when idle", 32'(resWr), 32'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog R5 actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rstN   = 1'b0;
    start  = 1'b0;
    lenM1  = '0;
    clrLog = 1'b1;
    for (int i = 0; i < DEPTH; i++) nMem[i] = '0;
    repeat (3) @(negedge clk);
    chk(ready == 1'b1, "R1 ready in reset", 32'(ready), 32'd1);
    chk(resWr == 1'b0, "R1 no write in reset", 32'(resWr), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    clrLog = 1'b0;
    repeat (3) @(negedge clk);
    chk(ready == 1'b1, "R1 ready after reset", 32'(ready), 32'd1);
    chk(wrCnt == 0, "R1 no write after reset", 32'(wrCnt), 32'd0);

    // R9 corners, explicit arithmetic values
    runCase(0, 512'd3, 1'b0, "R9 N=3");
    chk(rMem[0] == 32'd1, "R9 N=3 gives 1", rMem[0], 32'd1);
    runCase(1, mkOnes(2), 1'b0, "R9 all ones");
    chk(rMem[0] == 32'd1 && rMem[1] == 32'd0, "R9 all ones gives 1", rMem[0], 32'd1);

    // R3 sweep over small lengths and modulus shapes
    for (int len = 0; len < 4; len++) begin
      runCase(len, 512'd3, 1'b0, "R3 N=3");
      runCase(len, mkOnes(len + 1), 1'b0, "R3 all ones");
      runCase(len, mkTop(len + 1), 1'b0, "R9 top bit set");
      runCase(len, mkRand(len + 1), 1'b0, "R3 random");
      runCase(len, mkRand(len + 1), 1'b0, "R3 random");
    end

    // R6 start and length change while busy
    runCase(2, mkRand(3), 1'b1, "R6 busy start ignored");

    // R3 384-bit and 512-bit operands
    runCase(11, mkRand(12), 1'b0, "R3 384-bit");
    runCase(15, mkTop(16) | mkRand(16), 1'b0, "R3 512-bit");

    // R8 reset during an operation
    @(negedge clk);
    lenM1  = ADDR_W'(1);
    start  = 1'b1;
    clrLog = 1'b1;
    @(negedge clk);
    start  = 1'b0;
    clrLog = 1'b0;
    repeat (50) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chk(ready == 1'b1, "R8 ready after abort", 32'(ready), 32'd1);
    rstN = 1'b1;
    repeat (300) @(negedge clk);
    chk(wrCnt == 0, "R8 no write after abort", 32'(wrCnt), 32'd0);
    chk(ready == 1'b1, "R8 stays idle", 32'(ready), 32'd1);
    runCase(1, mkRand(2), 1'b0, "R8 run after abort");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule